// File: doc/BRIEF.md
# Dual Maskable Time-of-Day Alarm and Interrupt Router

This block watches a calendar clock that is kept elsewhere and raises interrupts when the current time agrees with one of two programmed alarm settings. The first alarm compares seconds, minutes, hours, and either weekday or day-of-month. The second alarm has no seconds field and can only fire when the seconds count is 00. Each alarm register carries a mask bit in its top bit. The combination of mask bits picks the repeat rate, from once per second up to once per month or once per week. The comparison is made only on the cycle where the external counter signals its once-per-second update. A match sets a sticky flag, and the flag stays set until software writes a zero to it.

The enabled flags drive two active-low interrupt lines, each modelled as an open-drain drive enable. A routing bit selects between two arrangements. In split routing, each alarm has its own line. In shared routing, both alarms use line A, and line B carries a square wave. That wave is divided from a sampled 32.768 kHz oscillator level at one of four rates.

Top module: `alarm_irq_unit`

## Requirements
- R1: With all four mask bits of alarm 1 set (bit 7 of its seconds, minutes, hours and day/date registers), every update pulse sets flag 1, whatever the time.
- R2: Alarm 1 mask patterns, written as day/date, hours, minutes, seconds mask bits: 1110 sets flag 1 when seconds match, 1100 when minutes and seconds match, and 1000 when hours, minutes and seconds match. Time fields compare on bits 6:0, which include the 12-hour select bit and the PM bit of the hours register.
- R3: With mask pattern 0000, the day/date field must also match. If bit 6 of the day/date register is 1, bits 2:0 are compared with the weekday. If bit 6 is 0, bits 5:0 are compared with the day of month.
- R4: Alarm 2 mask patterns, written as day/date, hours, minutes mask bits, always require current seconds equal to 00. The patterns are 111 (every minute), 110 (minutes match), 100 (hours and minutes match) and 000 (day/date, hours and minutes match, with the same bit 6 select as R3).
- R5: Every mask pattern not listed in R1 to R4 never sets a flag.
- R6: Flags are set only in the cycle that follows an update pulse. A matching time with no pulse leaves the flags unchanged.
- R7: With a flag write, each flag whose data bit is 0 is cleared, and each flag whose data bit is 1 keeps its value. If a match and a clear fall in the same cycle, the flag ends up set.
- R8: With routing bit 1, line A is low exactly when flag 1 and enable 1 are both set, and line B is low exactly when flag 2 and enable 2 are both set.
- R9: With routing bit 0, line A is low when either enabled flag is set, and line B carries the square wave.
- R10: Rate select 11 gives one cycle per oscillator period; 10 gives one cycle per 4 periods; 01 one per 8; 00 one per 32768 (1 Hz). Each has equal high and low time.
- R11: After reset, both flags and both enables are 0, the routing bit is 0 and the rate is 11. Line A is high and line B carries the fastest square wave. The control word is bits [1:0] enables (bit 0 alarm 1), bit 2 routing, bits [4:3] rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1s | input | 1 | One-cycle pulse when the time inputs have just advanced |
| osc_in | input | 1 | Synchronised 32.768 kHz oscillator level |
| t_sec | input | 7 | Current seconds, BCD |
| t_min | input | 7 | Current minutes, BCD |
| t_hour | input | 7 | Current hours with 12-hour and PM bits |
| t_wday | input | 3 | Current weekday 1..7 |
| t_mday | input | 6 | Current day of month, BCD |
| a1_sec | input | 8 | Alarm 1 seconds, bit 7 mask |
| a1_min | input | 8 | Alarm 1 minutes, bit 7 mask |
| a1_hour | input | 8 | Alarm 1 hours, bit 7 mask |
| a1_dd | input | 8 | Alarm 1 day/date, bit 7 mask, bit 6 weekday select |
| a2_min | input | 8 | Alarm 2 minutes, bit 7 mask |
| a2_hour | input | 8 | Alarm 2 hours, bit 7 mask |
| a2_dd | input | 8 | Alarm 2 day/date, bit 7 mask, bit 6 weekday select |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word: rate, routing, enables |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Flag write data, 0 clears |
| alarm_flag | output | 2 | Sticky alarm flags (bit 0 alarm 1) |
| irq_a_n | output | 1 | Line A drive enable, active low |
| irq_b_n | output | 1 | Line B drive enable or square wave |

## Verification
A wrong mask decode or a wrong field comparison shows up on the flag outputs one cycle after the update pulse that should, or should not, have set them. A stuck or lost flag shows up at the next flag write, or on the interrupt lines, which follow the flags with no added delay. A divider fault changes the high and low times of line B. This becomes visible within one output period, which for the 1 Hz rate means the bench must watch 32768 oscillator periods.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

    localparam int NUM_ALARMS = 2;
    localparam int DIV_W      = 15;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [6:0] hour;
        logic [2:0] wday;
        logic [5:0] mday;
    } now_t;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dd;
    } alarm_regs_t;

    typedef enum logic [1:0] {
        RATE_1HZ = 2'b00,
        RATE_4K  = 2'b01,
        RATE_8K  = 2'b10,
        RATE_32K = 2'b11
    } sq_rate_e;

    typedef struct packed {
        sq_rate_e                rate;
        logic                    split;
        logic [NUM_ALARMS-1:0]   ie;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{rate: RATE_32K, split: 1'b0, ie: '0};

    // Mask order {day/date, hour, min, sec}; only five patterns are legal.
    function automatic logic alarm_fires(alarm_regs_t a, now_t t);
        logic s_eq, m_eq, h_eq, d_eq;
        s_eq = (a.sec[6:0]  == t.sec);
        m_eq = (a.min[6:0]  == t.min);
        h_eq = (a.hour[6:0] == t.hour);
        d_eq = a.dd[6] ? (a.dd[2:0] == t.wday) : (a.dd[5:0] == t.mday);
        case ({a.dd[7], a.hour[7], a.min[7], a.sec[7]})
            4'b1111: return 1'b1;
            4'b1110: return s_eq;
            4'b1100: return s_eq & m_eq;
            4'b1000: return s_eq & m_eq & h_eq;
            4'b0000: return s_eq & m_eq & h_eq & d_eq;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_irq_pkg::*;
(
    input  alarm_regs_t regs,
    input  now_t        now,
    output logic        hit
);
    always_comb hit = alarm_fires(regs, now);
endmodule

// File: rtl/alarm_flags.sv
module alarm_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [N-1:0] hit,
    input  logic         wr_en,
    input  logic [N-1:0] wr_data,
    output logic [N-1:0] flag_q
);
    logic [N-1:0] keep_mask;
    logic [N-1:0] set_mask;

    always_comb begin
        keep_mask = wr_en ? wr_data : '1;
        set_mask  = tick ? hit : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (flag_q & keep_mask) | set_mask;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        p_set_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_q[i]) |-> $past(tick));
        p_clear_r7: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !wr_data[i] && !(tick && hit[i])) |=> !flag_q[i]);
        p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
            (flag_q[i] && !(wr_en && !wr_data[i])) |=> flag_q[i]);
    end
endmodule

// File: rtl/sq_divider.sv
module sq_divider
    import alarm_irq_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     osc_in,
    input  sq_rate_e rate,
    output logic     sq
);
    localparam int B_1HZ = W - 1;
    localparam int B_4K  = W - 13;
    localparam int B_8K  = W - 14;

    logic         osc_q;
    logic         osc_rise;
    logic [W-1:0] cnt;
    logic         sel;

    assign osc_rise = osc_in & ~osc_q;

    always_comb begin
        case (rate)
            RATE_1HZ: sel = cnt[B_1HZ];
            RATE_4K:  sel = cnt[B_4K];
            RATE_8K:  sel = cnt[B_8K];
            default:  sel = osc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_q <= 1'b0;
            cnt   <= '0;
            sq    <= 1'b0;
        end else begin
            osc_q <= osc_in;
            if (osc_rise) cnt <= cnt + 1'b1;
            sq <= sel;
        end
    end

    p_div_step_r10: assert property (@(posedge clk) disable iff (rst)
        !(osc_in && !osc_q) |=> $stable(cnt));
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
    import alarm_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1s,
    input  logic       osc_in,
    input  logic [6:0] t_sec,
    input  logic [6:0] t_min,
    input  logic [6:0] t_hour,
    input  logic [2:0] t_wday,
    input  logic [5:0] t_mday,
    input  logic [7:0] a1_sec,
    input  logic [7:0] a1_min,
    input  logic [7:0] a1_hour,
    input  logic [7:0] a1_dd,
    input  logic [7:0] a2_min,
    input  logic [7:0] a2_hour,
    input  logic [7:0] a2_dd,
    input  logic       ctl_we,
    input  logic [4:0] ctl_wdata,
    input  logic       flag_we,
    input  logic [1:0] flag_wdata,
    output logic [1:0] alarm_flag,
    output logic       irq_a_n,
    output logic       irq_b_n
);
    now_t                   now;
    alarm_regs_t            al_regs [NUM_ALARMS];
    logic [NUM_ALARMS-1:0]  hit;
    logic [NUM_ALARMS-1:0]  pend;
    ctl_t                   ctl_q;
    logic                   sq;

    assign now        = '{sec: t_sec, min: t_min, hour: t_hour, wday: t_wday, mday: t_mday};
    assign al_regs[0] = {a1_sec, a1_min, a1_hour, a1_dd};
    // Second alarm: seconds held unmasked at 00, so it fires only at second 00.
    assign al_regs[1] = {8'h00, a2_min, a2_hour, a2_dd};

    for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
        alarm_match u_match (.regs(al_regs[i]), .now(now), .hit(hit[i]));
    end

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= CTL_RESET;
        else if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);
    end

    alarm_flags #(.N(NUM_ALARMS)) u_flags (
        .clk(clk), .rst(rst), .tick(tick_1s), .hit(hit),
        .wr_en(flag_we), .wr_data(flag_wdata), .flag_q(alarm_flag)
    );

    sq_divider #(.W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .osc_in(osc_in), .rate(ctl_q.rate), .sq(sq)
    );

    assign pend    = alarm_flag & ctl_q.ie;
    assign irq_a_n = ctl_q.split ? ~pend[0] : ~|pend;
    assign irq_b_n = ctl_q.split ? ~pend[1] : sq;

    p_split_b_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.split && !(alarm_flag[1] && ctl_q.ie[1])) |-> irq_b_n);
    p_split_a_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.split && alarm_flag[0] && ctl_q.ie[0]) |-> !irq_a_n);
    p_shared_a_r9: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.split && alarm_flag[1] && ctl_q.ie[1]) |-> !irq_a_n);
    p_flag_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (!tick_1s && !$past(tick_1s) && $past(alarm_flag) == 2'b00) |-> alarm_flag == 2'b00);
endmodule

// File: tb/test_alarm_irq_unit.sv
module test_alarm_irq_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1s = 1'b0;
    logic       osc_in = 1'b0;
    logic [6:0] t_sec = '0, t_min = '0, t_hour = '0;
    logic [2:0] t_wday = 3'd1;
    logic [5:0] t_mday = 6'h01;
    logic [7:0] a1_sec = '0, a1_min = '0, a1_hour = '0, a1_dd = '0;
    logic [7:0] a2_min = '0, a2_hour = '0, a2_dd = '0;
    logic       ctl_we = 1'b0;
    logic [4:0] ctl_wdata = '0;
    logic       flag_we = 1'b0;
    logic [1:0] flag_wdata = '0;
    logic [1:0] alarm_flag;
    logic       irq_a_n, irq_b_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    alarm_irq_unit i_alarm_irq_unit (.*);

    always #10 clk = ~clk;
    initial forever begin @(negedge clk); osc_in = ~osc_in; end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_fire(input logic [3:0] m, input bit s, input bit mi,
                                    input bit h, input bit d);
        if (m == 4'b1111) return 1;
        if (m == 4'b1110) return s;
        if (m == 4'b1100) return s && mi;
        if (m == 4'b1000) return s && mi && h;
        if (m == 4'b0000) return s && mi && h && d;
        return 0;
    endfunction

    function automatic bit dd_eq(input logic [7:0] dd);
        return dd[6] ? (dd[2:0] == t_wday) : (dd[5:0] == t_mday);
    endfunction

    function automatic bit exp_a1();
        return exp_fire({a1_dd[7], a1_hour[7], a1_min[7], a1_sec[7]},
            a1_sec[6:0] == t_sec, a1_min[6:0] == t_min, a1_hour[6:0] == t_hour, dd_eq(a1_dd));
    endfunction

    function automatic bit exp_a2();
        return exp_fire({a2_dd[7], a2_hour[7], a2_min[7], 1'b0},
            t_sec == 7'h00, a2_min[6:0] == t_min, a2_hour[6:0] == t_hour, dd_eq(a2_dd));
    endfunction

    task automatic pulse_tick();
        @(negedge clk); tick_1s = 1'b1;
        @(negedge clk); tick_1s = 1'b0;
    endtask

    task automatic wr_flags(input logic [1:0] d);
        @(negedge clk); flag_we = 1'b1; flag_wdata = d;
        @(negedge clk); flag_we = 1'b0;
    endtask

    task automatic wr_ctl(input logic [1:0] rate, input bit split, input logic [1:0] ie);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = {rate, split, ie};
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic measure(input bit want_lo, output int hi, output int lo);
        logic prev;
        prev = irq_b_n;
        forever begin
            @(negedge clk);
            if (!prev && irq_b_n) break;
            prev = irq_b_n;
        end
        hi = 0; lo = 0;
        while (irq_b_n) begin hi++; @(negedge clk); end
        if (want_lo) while (!irq_b_n) begin lo++; @(negedge clk); end
    endtask

    task automatic set_always_both();
        a1_sec = 8'h80; a1_min = 8'h80; a1_hour = 8'h80; a1_dd = 8'h80;
        a2_min = 8'h80; a2_hour = 8'h80; a2_dd = 8'h80;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int hi, lo;
        logic [3:0] m;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk("R11 flags", alarm_flag, 0);
        chk("R11 irq_a_n", irq_a_n, 1);
        measure(1, hi, lo);
        chk("R11 sq hi", hi, 1);
        chk("R11 sq lo", lo, 1);

        // R6: matching alarm without pulse
        t_sec = 7'h00; set_always_both();
        repeat (3) @(negedge clk);
        chk("R6 no tick", alarm_flag, 0);

        // R1 and R4 every-minute
        t_sec = 7'h37; pulse_tick();
        chk("R1 every second", alarm_flag, 1);
        chk("R4 not at sec 37", alarm_flag[1], 0);
        t_sec = 7'h00; pulse_tick();
        chk("R4 at sec 00", alarm_flag[1], 1);

        // R7 partial clear, then set wins over clear
        wr_flags(2'b10);
        chk("R7 clear a1 keep a2", alarm_flag, 2);
        @(negedge clk); tick_1s = 1'b1; flag_we = 1'b1; flag_wdata = 2'b00;
        @(negedge clk); tick_1s = 1'b0; flag_we = 1'b0;
        chk("R7 set wins", alarm_flag, 3);
        wr_flags(2'b00);
        chk("R7 full clear", alarm_flag, 0);

        // R3 day versus date
        t_sec = 7'h05; t_min = 7'h10; t_hour = 7'h52; t_wday = 3'd3; t_mday = 6'h15;
        a1_sec = 8'h05; a1_min = 8'h10; a1_hour = 8'h52; a1_dd = 8'h43;
        pulse_tick(); chk("R3 weekday match", alarm_flag[0], 1); wr_flags(0);
        a1_dd = 8'h15; pulse_tick(); chk("R3 date match", alarm_flag[0], 1); wr_flags(0);
        a1_dd = 8'h16; pulse_tick(); chk("R3 date miss", alarm_flag[0], 0);
        a1_dd = 8'h44; pulse_tick(); chk("R3 weekday miss", alarm_flag[0], 0);

        // R2 hours include PM bit
        a1_dd = 8'h80; a1_hour = 8'h72; pulse_tick(); chk("R2 PM mismatch", alarm_flag[0], 0);

        // R5 illegal masks on both alarms, all fields matching
        t_sec = 7'h00; t_min = 7'h10; t_hour = 7'h52;
        a2_min = 8'h10; a2_hour = 8'h52; a2_dd = 8'h15;
        a1_sec = 8'h00; a1_min = 8'h10; a1_hour = 8'h52; a1_dd = 8'h15;
        for (int k = 0; k < 16; k++) begin
            m = 4'(k);
            if (m == 4'hF || m == 4'hE || m == 4'hC || m == 4'h8 || m == 4'h0) continue;
            a1_dd[7] = m[3]; a1_hour[7] = m[2]; a1_min[7] = m[1]; a1_sec[7] = m[0];
            a2_dd[7] = m[3]; a2_hour[7] = m[2]; a2_min[7] = m[1];
            wr_flags(0); pulse_tick();
            chk("R5 illegal a1", alarm_flag[0], 0);
            if (m[0] == 1'b0 && (m[3:1] != 3'b111 && m[3:1] != 3'b110 &&
                                 m[3:1] != 3'b100 && m[3:1] != 3'b000))
                chk("R5 illegal a2", alarm_flag[1], 0);
        end

        // R1/R2/R3/R4 constrained random
        for (int it = 0; it < 250; it++) begin
            int pick;
            logic [3:0] masks [5] = '{4'hF, 4'hE, 4'hC, 4'h8, 4'h0};
            pick = $urandom % 5; m = masks[pick];
            a1_sec = {m[0], 1'b0, 3'($urandom % 6), 3'($urandom % 3)};
            a1_min = {m[1], 1'b0, 3'($urandom % 6), 3'($urandom % 3)};
            a1_hour = {m[2], 7'($urandom % 3)};
            a1_dd = {m[3], 1'($urandom), 3'b0, 3'($urandom % 7 + 1)};
            pick = $urandom % 4; m = masks[pick + 1];
            a2_min = {m[1], 1'b0, 3'($urandom % 6), 3'($urandom % 3)};
            a2_hour = {m[2], 7'($urandom % 3)};
            a2_dd = {m[3], 1'($urandom), 3'b0, 3'($urandom % 7 + 1)};
            t_sec  = ($urandom % 2) ? a1_sec[6:0] : 7'($urandom % 3);
            t_min  = ($urandom % 2) ? a1_min[6:0] : a2_min[6:0];
            t_hour = ($urandom % 2) ? a1_hour[6:0] : a2_hour[6:0];
            t_wday = ($urandom % 2) ? a1_dd[2:0] : a2_dd[2:0];
            t_mday = ($urandom % 2) ? a1_dd[5:0] : a2_dd[5:0];
            wr_flags(0); pulse_tick();
            chk("R2 random alarm1", alarm_flag[0], exp_a1());
            chk("R4 random alarm2", alarm_flag[1], exp_a2());
        end

        // R8 split routing
        set_always_both(); wr_flags(0);
        wr_ctl(2'b11, 1'b1, 2'b11);
        t_sec = 7'h01; pulse_tick();
        chk("R8 a low", irq_a_n, 0); chk("R8 b high", irq_b_n, 1);
        wr_flags(2'b00); t_sec = 7'h00; pulse_tick(); wr_flags(2'b10);
        chk("R8 only a2 a", irq_a_n, 1); chk("R8 only a2 b", irq_b_n, 0);
        wr_ctl(2'b11, 1'b1, 2'b01);
        chk("R8 a2 disabled", irq_b_n, 1);

        // R9 shared routing
        wr_ctl(2'b11, 1'b0, 2'b10);
        @(negedge clk); chk("R9 a2 on A", irq_a_n, 0);
        wr_ctl(2'b11, 1'b0, 2'b00);
        @(negedge clk); chk("R9 disabled", irq_a_n, 1);

        // R10 rates
        wr_ctl(2'b10, 1'b0, 2'b00); measure(1, hi, lo);
        chk("R10 8k hi", hi, 4); chk("R10 8k lo", lo, 4);
        wr_ctl(2'b01, 1'b0, 2'b00); measure(1, hi, lo);
        chk("R10 4k hi", hi, 8); chk("R10 4k lo", lo, 8);
        wr_ctl(2'b00, 1'b0, 2'b00); measure(0, hi, lo);
        chk("R10 1Hz hi", hi, 32768);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule